// File: doc/BRIEF.md
# Flash Page Program-and-Verify Sequencer

This block writes one 32-byte page into an on-chip flash array. The host gives a start address, 32 data bytes, a per-byte valid mask and a one-cycle start strobe. The block then runs program pulses and verify passes by itself until the page reads back correctly. It finishes with a one-cycle done pulse or a one-cycle fail pulse. A flash bit erases to 1, and only 0 bits are ever programmed. Byte positions whose mask bit is clear are written as 0xFF, so they are left untouched.

On the flash side the block drives five levels: write enable, pulse setup, program, program-verify and a watchdog enable. It also issues byte writes and 32-bit verify reads. Between these steps it holds fixed waits measured in microseconds. All waits come from one down-counter, which is scaled by a parameter giving clock cycles per microsecond.

After every verify pass the block rebuilds an internal rewrite buffer from the original data D and the verify data V. Each rewrite bit is D OR NOT V. The next pass writes this buffer, so a bit that slips back to the erased state gets another pulse. The loop stops when the whole buffer is 0xFF, or when the pass limit is reached.

Top module: `flash_pgm_seq`

## Requirements
- R1: A start whose address bits [4:0] are not all zero raises `errO` for one cycle in the next cycle. No flash activity follows and `busyO` stays low.
- R2: A start that arrives while `busyO` is high raises `errO` for one cycle in the next cycle. The running operation continues and completes unchanged.
- R3: On the first pass, write enable is high and 32 byte writes follow to addresses base+0 through base+31 in rising order. The data for byte k is `dataI[8k+7:8k]` when `maskI[k]` is 1, and 0xFF when `maskI[k]` is 0.
- R4: Waits are counted in units of CYC_PER_US clock cycles, with these values:
  - Write enable is high for 10 us before the first byte write.
  - Setup is high for 50 us before program rises.
  - Program is high for exactly 200 us.
  - Setup falls 10 us after program falls.
  - Program is only ever high while setup is high.
- R5: Verify rises 4 us before the first longword. For each of the 8 longwords, at offset 4w (w = 0..7) in rising order, the block:
  - writes a dummy 0xFF to base+4w;
  - waits 2 us;
  - issues one read of base+4w.
  Byte base+4w+k is taken from `rdDataI[8k+7:8k]`.
- R6: Every pass after the first writes the 32 bytes, in the same address order, with rewrite value D OR NOT V for each byte. D is the filled host byte and V is the byte from the latest verify read. A bit that verified as programmed and later reads back as 1 is written as 0 again.
- R7: The watchdog enable is high on every cycle that program is high. It is low while verify is high.
- R8: When the rewrite buffer is all 0xFF after a verify pass, `doneO` pulses for one cycle. In that cycle write enable and `busyO` are already low.
- R9: When a verify pass still finds bits to rewrite after the MAX_PASS-th program pulse, `failO` pulses for one cycle. Write enable and `busyO` are low in that cycle. Exactly MAX_PASS pulses were issued.
- R10: After reset, every flash control level, `busyO`, `doneO`, `failO` and `errO` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | One-cycle start strobe |
| addrI | input | ADDR_W | Page start address, bits [4:0] must be zero |
| dataI | input | 256 | Page data, byte k in bits [8k+7:8k] |
| maskI | input | 32 | Byte valid mask, clear bytes are written as 0xFF |
| busyO | output | 1 | Operation in progress |
| doneO | output | 1 | One-cycle pulse, page programmed |
| failO | output | 1 | One-cycle pulse, pass limit reached |
| errO | output | 1 | One-cycle pulse, start rejected |
| weO | output | 1 | Flash write enable level |
| setupO | output | 1 | Program setup level |
| progO | output | 1 | Program pulse level |
| verifyO | output | 1 | Program-verify level |
| wdtEnO | output | 1 | Watchdog enable level |
| wrEnO | output | 1 | Byte write strobe |
| wrAddrO | output | ADDR_W | Byte write address |
| wrDataO | output | 8 | Byte write data |
| rdEnO | output | 1 | Longword verify read strobe |
| rdAddrO | output | ADDR_W | Verify read address |
| rdDataI | input | 32 | Verify read data, returned in the same cycle |

## Verification
The hardest case to reach is a bit that verifies as programmed in one pass and reads back erased in a later one. Only that case shows that the rewrite buffer is rebuilt from the original data rather than narrowed step by step. The bench flash model needs several pulses before some bytes take effect. It also lets the bench flip one bit back to 1 at the end of the first verify pass, while a second byte still needs three pulses. The bench then checks that the third pass writes the flipped bit as 0 again. A byte that needs more pulses than MAX_PASS drives the failure path.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

  localparam int PAGE_BYTES = 32;
  localparam int PAGE_WORDS = 8;

  // wait lengths in microseconds
  localparam logic [7:0] US_WEN   = 8'd10;
  localparam logic [7:0] US_SETUP = 8'd50;
  localparam logic [7:0] US_PULSE = 8'd200;
  localparam logic [7:0] US_PHOLD = 8'd10;
  localparam logic [7:0] US_SHOLD = 8'd10;
  localparam logic [7:0] US_PVON  = 8'd4;
  localparam logic [7:0] US_DUMMY = 8'd2;
  localparam logic [7:0] US_PVOFF = 8'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WEN, ST_WRITE, ST_SETUP, ST_PULSE, ST_PHOLD, ST_SHOLD,
    ST_PVON, ST_DUMMY, ST_VWAIT, ST_READ, ST_PVOFF, ST_CHECK
  } seqState_t;

  typedef struct packed {
    logic       capture;
    logic       tmrLoad;
    logic [7:0] tmrUs;
    logic       idxClr;
    logic       byteInc;
    logic       wordInc;
    logic       verUpdate;
    logic       passInc;
    logic       dummySel;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_pgm_dp.sv
module flash_pgm_dp
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CYC_PER_US = 1,
  parameter int MAX_PASS   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic [ADDR_W-6:0] pageI,
  input  logic [255:0]      dataI,
  input  logic [31:0]       maskI,
  input  logic [31:0]       rdDataI,
  output logic [ADDR_W-1:0] wrAddrO,
  output logic [7:0]        wrDataO,
  output logic [ADDR_W-1:0] rdAddrO,
  output logic              tmrZero,
  output logic              byteLast,
  output logic              wordLast,
  output logic              allOnes,
  output logic              passMax
);

  localparam int TMR_W  = $clog2(256 * CYC_PER_US + 1);
  localparam int PASS_W = $clog2(MAX_PASS + 1);

  logic [TMR_W-1:0]  tmrCnt;
  logic [PASS_W-1:0] passCnt;
  logic [ADDR_W-6:0] pageBase;
  logic [4:0]        byteIdx;
  logic [2:0]        wordIdx;
  logic [7:0]        dBuf [PAGE_BYTES];
  logic [7:0]        xBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] byteClean;

  // shared microsecond wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (st.tmrLoad) begin
      tmrCnt <= TMR_W'(int'(st.tmrUs) * CYC_PER_US - 1);
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      passCnt  <= '0;
      byteIdx  <= '0;
      wordIdx  <= '0;
      for (int k = 0; k < PAGE_BYTES; k++) begin
        dBuf[k] <= 8'hFF;
        xBuf[k] <= 8'hFF;
      end
    end else begin
      if (st.capture) begin
        pageBase <= pageI;
        passCnt  <= PASS_W'(1);
        for (int k = 0; k < PAGE_BYTES; k++) begin
          dBuf[k] <= maskI[k] ? dataI[8*k +: 8] : 8'hFF;
          xBuf[k] <= maskI[k] ? dataI[8*k +: 8] : 8'hFF;
        end
      end else begin
        if (st.passInc) passCnt <= passCnt + 1'b1;
        if (st.verUpdate) begin
          for (int j = 0; j < 4; j++) begin
            xBuf[{wordIdx, 2'(j)}] <= dBuf[{wordIdx, 2'(j)}] | ~rdDataI[8*j +: 8];
          end
        end
      end
      if (st.idxClr) begin
        byteIdx <= '0;
        wordIdx <= '0;
      end else begin
        if (st.byteInc) byteIdx <= byteIdx + 1'b1;
        if (st.wordInc) wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gClean
    assign byteClean[g] = &xBuf[g];
  end

  assign allOnes  = &byteClean;
  assign tmrZero  = (tmrCnt == '0);
  assign byteLast = (byteIdx == 5'd31);
  assign wordLast = (wordIdx == 3'd7);
  assign passMax  = (passCnt >= PASS_W'(MAX_PASS));

  assign wrAddrO = st.dummySel ? {pageBase, wordIdx, 2'b00} : {pageBase, byteIdx};
  assign wrDataO = st.dummySel ? 8'hFF : xBuf[byteIdx];
  assign rdAddrO = {pageBase, wordIdx, 2'b00};

endmodule

// File: rtl/flash_pgm_ctl.sv
module flash_pgm_ctl
  import flash_pgm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic       aligned,
  input  logic       tmrZero,
  input  logic       byteLast,
  input  logic       wordLast,
  input  logic       allOnes,
  input  logic       passMax,
  output ctlStrobe_t st,
  output logic       busyO,
  output logic       doneO,
  output logic       failO,
  output logic       errO,
  output logic       weO,
  output logic       setupO,
  output logic       progO,
  output logic       verifyO,
  output logic       wdtEnO,
  output logic       wrEnO,
  output logic       rdEnO
);

  seqState_t state, nxt;

  always_comb begin
    nxt = state;
    st  = '0;
    unique case (state)
      ST_IDLE: if (startI && aligned) begin
        st.capture = 1'b1; st.tmrLoad = 1'b1; st.tmrUs = US_WEN; nxt = ST_WEN;
      end
      ST_WEN: if (tmrZero) begin
        st.idxClr = 1'b1; nxt = ST_WRITE;
      end
      ST_WRITE: begin
        st.byteInc = 1'b1;
        if (byteLast) begin
          st.tmrLoad = 1'b1; st.tmrUs = US_SETUP; nxt = ST_SETUP;
        end
      end
      ST_SETUP: if (tmrZero) begin
        st.tmrLoad = 1'b1; st.tmrUs = US_PULSE; nxt = ST_PULSE;
      end
      ST_PULSE: if (tmrZero) begin
        st.tmrLoad = 1'b1; st.tmrUs = US_PHOLD; nxt = ST_PHOLD;
      end
      ST_PHOLD: if (tmrZero) begin
        st.tmrLoad = 1'b1; st.tmrUs = US_SHOLD; nxt = ST_SHOLD;
      end
      ST_SHOLD: if (tmrZero) begin
        st.tmrLoad = 1'b1; st.tmrUs = US_PVON; st.idxClr = 1'b1; nxt = ST_PVON;
      end
      ST_PVON: if (tmrZero) nxt = ST_DUMMY;
      ST_DUMMY: begin
        st.dummySel = 1'b1; st.tmrLoad = 1'b1; st.tmrUs = US_DUMMY; nxt = ST_VWAIT;
      end
      ST_VWAIT: if (tmrZero) nxt = ST_READ;
      ST_READ: begin
        st.verUpdate = 1'b1; st.wordInc = 1'b1;
        if (wordLast) begin
          st.tmrLoad = 1'b1; st.tmrUs = US_PVOFF; nxt = ST_PVOFF;
        end else begin
          nxt = ST_DUMMY;
        end
      end
      ST_PVOFF: if (tmrZero) nxt = ST_CHECK;
      ST_CHECK: begin
        if (allOnes || passMax) begin
          nxt = ST_IDLE;
        end else begin
          st.passInc = 1'b1; st.idxClr = 1'b1; nxt = ST_WRITE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneO <= 1'b0;
      failO <= 1'b0;
      errO  <= 1'b0;
    end else begin
      state <= nxt;
      doneO <= (state == ST_CHECK) && allOnes;
      failO <= (state == ST_CHECK) && !allOnes && passMax;
      errO  <= startI && ((state != ST_IDLE) || !aligned);
    end
  end

  assign busyO   = (state != ST_IDLE);
  assign weO     = busyO;
  assign setupO  = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_PHOLD);
  assign progO   = (state == ST_PULSE);
  assign wdtEnO  = setupO || (state == ST_SHOLD);
  assign verifyO = (state == ST_PVON) || (state == ST_DUMMY) ||
                   (state == ST_VWAIT) || (state == ST_READ);
  assign wrEnO   = (state == ST_WRITE) || (state == ST_DUMMY);
  assign rdEnO   = (state == ST_READ);

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CYC_PER_US = 1,
  parameter int MAX_PASS   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [ADDR_W-1:0] addrI,
  input  logic [255:0]      dataI,
  input  logic [31:0]       maskI,
  output logic              busyO,
  output logic              doneO,
  output logic              failO,
  output logic              errO,
  output logic              weO,
  output logic              setupO,
  output logic              progO,
  output logic              verifyO,
  output logic              wdtEnO,
  output logic              wrEnO,
  output logic [ADDR_W-1:0] wrAddrO,
  output logic [7:0]        wrDataO,
  output logic              rdEnO,
  output logic [ADDR_W-1:0] rdAddrO,
  input  logic [31:0]       rdDataI
);

  ctlStrobe_t st;
  logic tmrZero, byteLast, wordLast, allOnes, passMax;
  logic aligned;

  assign aligned = (addrI[4:0] == 5'd0);

  flash_pgm_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startI(startI), .aligned(aligned),
    .tmrZero(tmrZero), .byteLast(byteLast), .wordLast(wordLast),
    .allOnes(allOnes), .passMax(passMax), .st(st),
    .busyO(busyO), .doneO(doneO), .failO(failO), .errO(errO),
    .weO(weO), .setupO(setupO), .progO(progO), .verifyO(verifyO),
    .wdtEnO(wdtEnO), .wrEnO(wrEnO), .rdEnO(rdEnO)
  );

  flash_pgm_dp #(.ADDR_W(ADDR_W), .CYC_PER_US(CYC_PER_US), .MAX_PASS(MAX_PASS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .pageI(addrI[ADDR_W-1:5]),
    .dataI(dataI), .maskI(maskI), .rdDataI(rdDataI),
    .wrAddrO(wrAddrO), .wrDataO(wrDataO), .rdAddrO(rdAddrO),
    .tmrZero(tmrZero), .byteLast(byteLast), .wordLast(wordLast),
    .allOnes(allOnes), .passMax(passMax)
  );

endmodule

// File: rtl/flash_pgm_seq_chk.sv
module flash_pgm_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startI,
  input logic [ADDR_W-1:0] addrI,
  input logic              busyO,
  input logic              doneO,
  input logic              failO,
  input logic              errO,
  input logic              weO,
  input logic              setupO,
  input logic              progO,
  input logic              verifyO,
  input logic              wdtEnO,
  input logic              wrEnO,
  input logic [7:0]        wrDataO,
  input logic              rdEnO
);

  assert_misalign_err_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO && addrI[4:0] != 5'd0) |=> (errO && !busyO));

  assert_busy_err_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startI && busyO) |=> errO);

  assert_write_in_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEnO |-> (weO && !setupO));

  assert_prog_in_setup_R4: assert property (@(posedge clk) disable iff (!rstN)
    progO |-> setupO);

  assert_dummy_ff_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnO && verifyO) |-> (wrDataO == 8'hFF));

  assert_read_in_verify_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdEnO |-> (verifyO && !setupO));

  assert_wdt_cover_R7: assert property (@(posedge clk) disable iff (!rstN)
    progO |-> wdtEnO);

  assert_wdt_off_verify_R7: assert property (@(posedge clk) disable iff (!rstN)
    verifyO |-> !wdtEnO);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (!weO && !busyO && !failO));

  assert_fail_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    failO |-> (!weO && !busyO));

endmodule

bind flash_pgm_seq flash_pgm_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_pgm_seq_tb.sv
module flash_pgm_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int CYC = 2;
  localparam int MP  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          startI = 1'b0;
  logic [AW-1:0] addrI = '0;
  logic [255:0]  dataI = '0;
  logic [31:0]   maskI = '0;
  logic busyO, doneO, failO, errO, weO, setupO, progO, verifyO, wdtEnO, wrEnO, rdEnO;
  logic [AW-1:0] wrAddrO, rdAddrO;
  logic [7:0]    wrDataO;
  logic [31:0]   rdDataI;

  flash_pgm_seq #(.ADDR_W(AW), .CYC_PER_US(CYC), .MAX_PASS(MP)) u_dut (
    .clk(clk), .rstN(rstN), .startI(startI), .addrI(addrI), .dataI(dataI),
    .maskI(maskI), .busyO(busyO), .doneO(doneO), .failO(failO), .errO(errO),
    .weO(weO), .setupO(setupO), .progO(progO), .verifyO(verifyO),
    .wdtEnO(wdtEnO), .wrEnO(wrEnO), .wrAddrO(wrAddrO), .wrDataO(wrDataO),
    .rdEnO(rdEnO), .rdAddrO(rdAddrO), .rdDataI(rdDataI)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model
  logic [7:0] mem   [256];
  logic [7:0] latch [256];
  int         need  [256];
  int         hits  [256];
  logic [7:0] fill  [32];
  logic [7:0] xExp  [32];
  logic [7:0] opBase;
  int  wrIdx, wIdx, pulses, weCnt, preCnt, postCnt, progCnt, pvCnt, vwCnt;
  bit  firstWr, afterProg, dummySeen, prevProg, prevSetup, prevVerify;
  bit  disturbArm;
  logic [7:0] disturbAddr;
  int  disturbBit;
  logic [7:0] p3Byte;

  assign rdDataI = {mem[rdAddrO + 8'd3], mem[rdAddrO + 8'd2], mem[rdAddrO + 8'd1], mem[rdAddrO]};

  always @(negedge clk) begin
    if (rstN) begin
      // R4: write enable lead time
      if (!weO) begin
        weCnt = 0; firstWr = 0;
      end else if (wrEnO && !verifyO && !firstWr) begin
        chk("R4 we lead", weCnt, 10*CYC); firstWr = 1;
      end else if (!firstWr) begin
        weCnt++;
      end
      // byte writes, R3 first pass, R6 later passes
      if (wrEnO && !verifyO) begin
        latch[wrAddrO] = wrDataO;
        chk(pulses == 0 ? "R3 wr addr" : "R6 wr addr", wrAddrO, opBase + 8'(wrIdx));
        chk(pulses == 0 ? "R3 wr data" : "R6 wr data", wrDataO, xExp[wrIdx]);
        if (pulses == 2 && wrAddrO == disturbAddr) p3Byte = wrDataO;
        wrIdx = (wrIdx + 1) % 32;
      end
      // program pulse
      if (progO && !prevProg) begin
        chk("R4 setup lead", preCnt, 50*CYC);
        chk("R7 wdt at pulse", wdtEnO, 1);
        afterProg = 1; progCnt = 0; pulses++;
        for (int b = 0; b < 32; b++) begin
          if (latch[opBase + 8'(b)] != 8'hFF) begin
            hits[opBase + 8'(b)]++;
            if (hits[opBase + 8'(b)] >= need[opBase + 8'(b)])
              mem[opBase + 8'(b)] = mem[opBase + 8'(b)] & latch[opBase + 8'(b)];
          end
        end
      end
      if (progO) progCnt++;
      if (!progO && prevProg) chk("R4 pulse width", progCnt, 200*CYC);
      if (setupO && !progO && !afterProg) preCnt++;
      if (setupO && !progO && afterProg) postCnt++;
      if (!setupO && prevSetup) begin
        chk("R4 setup hold", postCnt, 10*CYC);
        preCnt = 0; postCnt = 0; afterProg = 0;
      end
      // verify pass, R5
      if (verifyO && !prevVerify) begin
        pvCnt = 0; dummySeen = 0; wIdx = 0;
        chk("R7 wdt off in verify", wdtEnO, 0);
      end
      if (wrEnO && verifyO) begin
        if (wIdx == 0) chk("R5 verify lead", pvCnt, 4*CYC);
        chk("R5 dummy data", wrDataO, 8'hFF);
        chk("R5 dummy addr", wrAddrO, opBase + 8'(4*wIdx));
        dummySeen = 1; vwCnt = 0;
      end else if (rdEnO) begin
        chk("R5 read wait", vwCnt, 2*CYC);
        chk("R5 read addr", rdAddrO, opBase + 8'(4*wIdx));
        for (int j = 0; j < 4; j++)
          xExp[4*wIdx + j] = fill[4*wIdx + j] | ~mem[rdAddrO + 8'(j)];
        wIdx++; dummySeen = 0;
      end else if (verifyO && dummySeen) begin
        vwCnt++;
      end else if (verifyO && wIdx == 0) begin
        pvCnt++;
      end
      if (!verifyO && prevVerify && disturbArm && pulses == 1) begin
        mem[disturbAddr][disturbBit] = 1'b1;
        disturbArm = 0;
      end
      prevProg = progO; prevSetup = setupO; prevVerify = verifyO;
    end
  end

  task automatic runOp(input logic [7:0] base, input bit poke, output bit gotDone, output bit gotFail);
    opBase = base;
    for (int b = 0; b < 32; b++) begin
      mem[base + 8'(b)] = 8'hFF; latch[base + 8'(b)] = 8'hFF;
      hits[base + 8'(b)] = 0; xExp[b] = fill[b];
    end
    wrIdx = 0; wIdx = 0; pulses = 0;
    @(negedge clk); addrI = base; startI = 1'b1;
    @(negedge clk); startI = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      startI = 1'b1; addrI = base ^ 8'h20;
      @(negedge clk); startI = 1'b0;
      chk("R2 err on busy start", errO, 1);
      chk("R2 still busy", busyO, 1);
    end
    forever begin
      @(negedge clk);
      if (doneO || failO) break;
    end
    gotDone = doneO; gotFail = failO;
    chk("R8 R9 we low at end", {weO, busyO}, 0);
  endtask

  task automatic doOp(input logic [7:0] base, input logic [255:0] d, input logic [31:0] m, input bit poke);
    int maxNeed;
    bit gd, gf;
    int mism;
    maxNeed = 1;
    dataI = d; maskI = m;
    for (int b = 0; b < 32; b++) begin
      fill[b] = m[b] ? d[8*b +: 8] : 8'hFF;
      if (fill[b] != 8'hFF && need[base + 8'(b)] > maxNeed) maxNeed = need[base + 8'(b)];
    end
    runOp(base, poke, gd, gf);
    if (maxNeed <= MP) begin
      chk("R8 done", {gd, gf}, 2'b10);
      chk("R8 pulse count", pulses, maxNeed);
    end else begin
      chk("R9 fail", {gd, gf}, 2'b01);
      chk("R9 pulse count", pulses, MP);
    end
    mism = 0;
    for (int b = 0; b < 32; b++)
      if (need[base + 8'(b)] <= MP && mem[base + 8'(b)] != fill[b]) mism++;
    chk("R6 R8 page content", mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] rd;
    void'($urandom(32'd2024));
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'hFF; latch[a] = 8'hFF; need[a] = 1; hits[a] = 0;
    end
    disturbArm = 0; disturbAddr = 8'h00; disturbBit = 0; p3Byte = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset outputs",
        {weO, setupO, progO, verifyO, wdtEnO, busyO, doneO, failO, errO, wrEnO, rdEnO}, 0);

    // R1: misaligned start
    addrI = 8'h45; startI = 1'b1;
    @(negedge clk); startI = 1'b0;
    chk("R1 err pulse", errO, 1);
    chk("R1 not busy", busyO, 0);
    repeat (5) @(negedge clk);
    chk("R1 no activity", {weO, wrEnO, errO}, 0);

    // directed: all erased data, one pulse
    doOp(8'h20, {256{1'b1}}, 32'hFFFF_FFFF, 0);
    // directed: all zero, partial mask (R3 fill)
    doOp(8'h40, 256'd0, 32'h0F0F_00FF, 0);
    // directed: multi-pulse bytes with a busy start poke (R2)
    for (int a = 0; a < 256; a++) need[a] = 1;
    need[8'h60 + 8'd5] = 3; need[8'h60 + 8'd31] = 2;
    doOp(8'h60, {8{32'h1234_5A00}}, 32'hFFFF_FFFF, 1);

    // R6: disturbed bit must be rewritten on pass 3
    for (int a = 0; a < 256; a++) need[a] = 1;
    need[8'h80 + 8'd9] = 3;
    disturbAddr = 8'h80 + 8'd2; disturbBit = 3; disturbArm = 1; p3Byte = 8'hFF;
    doOp(8'h80, {32{8'h00}}, 32'hFFFF_FFFF, 0);
    chk("R6 reprogram disturbed bit", p3Byte[3], 0);

    // R9: a byte that never takes
    for (int a = 0; a < 256; a++) need[a] = 1;
    need[8'hA0 + 8'd17] = MP + 3;
    doOp(8'hA0, {32{8'hC3}}, 32'hFFFF_FFFF, 0);

    // random operations
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      for (int a = 0; a < 256; a++) need[a] = 1 + int'($urandom % 3);
      if ($urandom % 5 == 0) need[$urandom % 256] = MP + 1;
      for (int k = 0; k < 8; k++) rd[32*k +: 32] = $urandom;
      b = 8'($urandom % 8) << 5;
      doOp(b, rd, $urandom | $urandom, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule